// File: doc/BRIEF.md
# Interval Measurement Controller

This block times the gap between a start event and a stop event. It counts both edges of its measurement clock, so each clock cycle of interval adds two to the result. Software issues one of four commands to drive it: abort, run, run synchronized to a fresh start edge, or clear. It can also pick the active edge of each event input and set an encoded saturation threshold. An optional skip counter lets a measurement ignore a programmed number of stop events. With it, one engine can measure a period, a pulse width, or the time from a start to the Nth stop. Status outputs give the result, a completion flag, a saturation flag and a 6-bit state code.

Start and stop events are single-bit inputs that are sampled by the block's clock. The edge-counting clock is modelled synchronously, as two counts per cycle. The saturation threshold, the skip enable and the skip load value are all captured when a run command is accepted. This means a change made while a measurement is in flight cannot disturb it.

Top module: `tdc_meas`

## Requirements
- R1: Out of reset the result is 2, the done and saturation flags are 0, the state code is 0x06 (idle) and the live skip count is 0.
- R2: Command code 0 (abort) returns the state code to 0x06 in the next cycle and does not set the done flag.
- R3: While counting, the result grows by 2 every clock cycle. A measurement whose start is accepted at clock edge a and whose final stop is seen at edge b reports 2*(b-a). In idle the result holds still.
- R4: A polarity input of 0 makes the matching event act on a low-to-high transition. A polarity of 1 makes it act on a high-to-low transition.
- R5: Command code 1 (run) moves to the waiting state 0x0A and begins counting (state 0x0F) on the first cycle in which the start input is at its active level. Command code 2 (run-sync) waits in 0x0A until a fresh active start edge, even when the start input is already active.
- R6: The saturation threshold is 2^(limit + CNT_W - 2^LIM_W). When the count reaches it, the measurement ends with the result equal to threshold + 4 and both flags set.
- R7: The done flag rises only on leaving the counting state. Command codes 1, 2 and 3 clear both flags. Code 3 (clear) also returns the result to 2.
- R8: With skipping enabled, the load value becomes the live skip count when the start is accepted. Each stop edge while the live count is nonzero decrements it. The stop edge that finds the live count at zero ends the measurement. A stop edge that arrives together with the accepted start edge also consumes one skip.
- R9: With start and stop on the same signal and the same polarity, a skip value of 0 or 1 gives one period and N gives N periods. With opposite polarities and skip 0, the result is the pulse width.
- R10: A write to the live skip count replaces it while it is nonzero. The write is ignored while it is zero.
- R11: With skipping disabled at the run command, the first stop edge ends the measurement and the live skip count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd | input | 2 | Command code: 0 abort, 1 run, 2 run-sync, 3 clear |
| start_evt | input | 1 | Start event input |
| start_pol | input | 1 | Start polarity: 0 rising, 1 falling |
| stop_evt | input | 1 | Stop event input |
| stop_pol | input | 1 | Stop polarity: 0 rising, 1 falling |
| sat_limit | input | LIM_W | Encoded saturation threshold |
| skip_en | input | 1 | Enable stop-event skipping |
| skip_load | input | SKIP_W | Skip count loaded at measurement start |
| skip_wr | input | 1 | Write strobe for the live skip count |
| skip_wdata | input | SKIP_W | Data for the live skip count |
| skip_live | output | SKIP_W | Remaining stop events to ignore |
| result | output | CNT_W | Edge count of the last measurement |
| done | output | 1 | Measurement complete |
| sat | output | 1 | Measurement ended by saturation |
| state | output | 6 | State code |

## Verification
The bench builds the block with CNT_W=12, LIM_W=3 and SKIP_W=8. Limit codes 0 and 1 then put the saturation threshold at 16 and 32 edges, so the saturation overshoot can be observed within a few dozen cycles. The 8-bit skip count keeps the multi-stop, period and live-rewrite cases short. Event edges are placed at fixed cycle offsets from the accepted start, so every expected result follows directly from the edge count.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [5:0] {
    ST_IDLE  = 6'h06,
    ST_WAIT  = 6'h0A,
    ST_COUNT = 6'h0F
  } tdc_state_e;

  typedef enum logic [1:0] {
    CMD_ABORT    = 2'd0,
    CMD_RUN      = 2'd1,
    CMD_RUN_SYNC = 2'd2,
    CMD_CLEAR    = 2'd3
  } tdc_cmd_e;

  localparam int unsigned RESULT_RESET    = 2;
  localparam int unsigned EDGES_PER_CYCLE = 2;
endpackage

// File: rtl/tdc_edge_det.sv
module tdc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic pol,
  output logic active,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= evt;
  end

  // active level after polarity; an edge is entry into the active level
  assign active = evt ^ pol;
  assign edge_o = active & ~(prev_q ^ pol);
endmodule

// File: rtl/tdc_sat_dec.sv
module tdc_sat_dec #(
  parameter int CNT_W = 25,
  parameter int LIM_W = 4
) (
  input  logic [LIM_W-1:0] limit,
  input  logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam int LIM_TOP    = (1 << LIM_W) - 1;
  localparam int SHIFT_BASE = CNT_W - 1 - LIM_TOP;

  logic [CNT_W-1:0] thr;

  assign thr = CNT_W'(1) << (SHIFT_BASE + int'(limit));
  assign hit = (count >= thr);
endmodule

// File: rtl/tdc_skip_ctr.sv
module tdc_skip_ctr #(
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [SKIP_W-1:0] load_val,
  input  logic              coinc,
  input  logic              dec_en,
  input  logic              wr_en,
  input  logic [SKIP_W-1:0] wr_data,
  output logic [SKIP_W-1:0] live,
  output logic              zero
);
  logic [SKIP_W-1:0] live_d;
  logic              live_en;

  assign zero = (live == '0);

  always_comb begin
    live_d  = live;
    live_en = 1'b0;
    if (load_en) begin
      live_en = 1'b1;
      live_d  = (coinc && load_val != '0) ? load_val - SKIP_W'(1) : load_val;
    end else if (wr_en && !zero) begin
      live_en = 1'b1;
      live_d  = wr_data;
    end else if (dec_en && !zero) begin
      live_en = 1'b1;
      live_d  = live - SKIP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live <= '0;
    else if (live_en) live <= live_d;
  end
endmodule

// File: rtl/tdc_meas.sv
module tdc_meas
  import tdc_pkg::*;
#(
  parameter int CNT_W  = 25,
  parameter int LIM_W  = 4,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd,
  input  logic              start_evt,
  input  logic              start_pol,
  input  logic              stop_evt,
  input  logic              stop_pol,
  input  logic [LIM_W-1:0]  sat_limit,
  input  logic              skip_en,
  input  logic [SKIP_W-1:0] skip_load,
  input  logic              skip_wr,
  input  logic [SKIP_W-1:0] skip_wdata,
  output logic [SKIP_W-1:0] skip_live,
  output logic [CNT_W-1:0]  result,
  output logic              done,
  output logic              sat,
  output logic [5:0]        state
);
  localparam int NUM_EVT = 2;
  localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(RESULT_RESET);
  localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(EDGES_PER_CYCLE);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // event channels: index 0 start, index 1 stop
  logic [NUM_EVT-1:0] evt_vec, pol_vec, act_vec, edge_vec;
  assign evt_vec = {stop_evt, start_evt};
  assign pol_vec = {stop_pol, start_pol};

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    tdc_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .evt   (evt_vec[g]),
      .pol   (pol_vec[g]),
      .active(act_vec[g]),
      .edge_o(edge_vec[g])
    );
  end

  tdc_cmd_e   cmd_e;
  tdc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d, sat_q, sat_d, hit_q, hit_d;
  logic sync_q, skip_en_q;
  logic [LIM_W-1:0] limit_q;
  logic arm, accept, sat_hit, skip_zero, skip_load_en, skip_dec;

  assign cmd_e = tdc_cmd_e'(cmd);
  assign arm   = cmd_wr && (cmd_e == CMD_RUN || cmd_e == CMD_RUN_SYNC);

  tdc_sat_dec #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_sat (
    .limit(limit_q),
    .count(cnt_q),
    .hit  (sat_hit)
  );

  assign skip_load_en = accept && skip_en_q;
  assign skip_dec     = !cmd_wr && (state_q == ST_COUNT) && !hit_q &&
                        edge_vec[1] && skip_en_q;

  tdc_skip_ctr #(.SKIP_W(SKIP_W)) u_skip (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (skip_load_en),
    .load_val(skip_load),
    .coinc   (edge_vec[1]),
    .dec_en  (skip_dec),
    .wr_en   (skip_wr),
    .wr_data (skip_wdata),
    .live    (skip_live),
    .zero    (skip_zero)
  );

  // next-state and datapath
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    sat_d   = sat_q;
    hit_d   = hit_q;
    accept  = 1'b0;
    if (cmd_wr) begin
      unique case (cmd_e)
        CMD_ABORT: state_d = ST_IDLE;
        CMD_RUN, CMD_RUN_SYNC: begin
          state_d = ST_WAIT;
          done_d  = 1'b0;
          sat_d   = 1'b0;
          hit_d   = 1'b0;
        end
        CMD_CLEAR: begin
          done_d = 1'b0;
          sat_d  = 1'b0;
          cnt_d  = CNT_RST;
        end
        default: ;
      endcase
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (sync_q ? edge_vec[0] : act_vec[0]) begin
            accept  = 1'b1;
            state_d = ST_COUNT;
            cnt_d   = '0;
          end
        end
        ST_COUNT: begin
          cnt_d = cnt_q + CNT_STEP;
          hit_d = sat_hit;
          if (hit_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            sat_d   = 1'b1;
          end else if (edge_vec[1] && !(skip_en_q && !skip_zero) &&
                       !(skip_wr && !skip_zero)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= CNT_RST;
      done_q  <= 1'b0;
      sat_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      sat_q   <= sat_d;
      hit_q   <= hit_d;
    end
  end

  // configuration captured at the run command
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sync_q    <= 1'b0;
      skip_en_q <= 1'b0;
      limit_q   <= '1;
    end else if (arm) begin
      sync_q    <= (cmd_e == CMD_RUN_SYNC);
      skip_en_q <= skip_en;
      limit_q   <= sat_limit;
    end
  end

  assign result = cnt_q;
  assign done   = done_q;
  assign sat    = sat_q;
  assign state  = state_q;
endmodule

// File: rtl/tdc_meas_chk.sv
module tdc_meas_chk #(
  parameter int CNT_W  = 25,
  parameter int SKIP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic [1:0]        cmd,
  input logic              skip_wr,
  input logic [SKIP_W-1:0] skip_live,
  input logic [CNT_W-1:0]  result,
  input logic              done,
  input logic              sat,
  input logic [5:0]        state
);
  a_r5_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state == 6'h06 || state == 6'h0A || state == 6'h0F);

  a_r6_sat_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> done);

  a_r7_clear_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 2'd3) |=> (!done && !sat && result == CNT_W'(2)));

  a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == 6'h0F);

  a_r2_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 2'd0) |=> state == 6'h06);

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'h0F && !cmd_wr) |=> result == $past(result) + CNT_W'(2));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'h06 && !cmd_wr) |=> $stable(result));

  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_wr && skip_live == '0 && state == 6'h06) |=> skip_live == '0);
endmodule

bind tdc_meas tdc_meas_chk #(.CNT_W(CNT_W), .SKIP_W(SKIP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_wr   (cmd_wr),
  .cmd      (cmd),
  .skip_wr  (skip_wr),
  .skip_live(skip_live),
  .result   (result),
  .done     (done),
  .sat      (sat),
  .state    (state)
);

// File: tb/tdc_meas_tb.sv
module tdc_meas_tb;
  localparam int CNT_W  = 12;
  localparam int LIM_W  = 3;
  localparam int SKIP_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_wr;
  logic [1:0] cmd;
  logic start_evt, start_pol, stop_evt, stop_pol;
  logic [LIM_W-1:0] sat_limit;
  logic skip_en, skip_wr;
  logic [SKIP_W-1:0] skip_load, skip_wdata, skip_live;
  logic [CNT_W-1:0] result;
  logic done, sat;
  logic [5:0] state;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    string req;
    int    res;
    bit    sat;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  tdc_meas #(.CNT_W(CNT_W), .LIM_W(LIM_W), .SKIP_W(SKIP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd),
    .start_evt(start_evt), .start_pol(start_pol),
    .stop_evt(stop_evt), .stop_pol(stop_pol),
    .sat_limit(sat_limit), .skip_en(skip_en), .skip_load(skip_load),
    .skip_wr(skip_wr), .skip_wdata(skip_wdata), .skip_live(skip_live),
    .result(result), .done(done), .sat(sat), .state(state)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(string req, int res, bit s);
    exp_t e;
    e.req = req; e.res = res; e.sat = s;
    sb_q.push_back(e);
  endtask

  task automatic send_cmd(int c);
    @(negedge clk);
    cmd_wr = 1'b1; cmd = 2'(c);
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic quiet();
    @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0;
    start_pol = 1'b0; stop_pol = 1'b0;
    skip_en = 1'b0; skip_load = '0; skip_wr = 1'b0;
    sat_limit = '1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  // monitor: compare each completed measurement with the scoreboard
  initial begin
    bit done_prev = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done && !done_prev) begin
        if (sb_q.size() == 0) begin
          chk("R7 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(e.req, int'(result), e.res);
          chk(e.req, int'(sat), int'(e.sat));
        end
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd = 2'd0;
    start_evt = 1'b0; stop_evt = 1'b0; start_pol = 1'b0; stop_pol = 1'b0;
    sat_limit = '1; skip_en = 1'b0; skip_load = '0; skip_wr = 1'b0;
    skip_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 result", int'(result), 2);
    chk("R1 done", int'(done), 0);
    chk("R1 sat", int'(sat), 0);
    chk("R1 state", int'(state), 6);
    chk("R1 skip_live", int'(skip_live), 0);

    // R3 basic rising-edge interval of 5 cycles
    quiet();
    push_exp("R3 basic", 10, 0);
    send_cmd(2);
    start_evt = 1'b1;
    repeat (5) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();
    chk("R7 done set", int'(done), 1);
    chk("R3 back to idle", int'(state), 6);

    // R4 falling polarity on both inputs
    quiet();
    start_pol = 1'b1; stop_pol = 1'b1; start_evt = 1'b1; stop_evt = 1'b1;
    push_exp("R4 falling", 10, 0);
    send_cmd(2);
    start_evt = 1'b0;
    repeat (5) @(negedge clk);
    stop_evt = 1'b0;
    wait_done();

    // R5 level-qualified run with start already active
    quiet();
    start_evt = 1'b1;
    push_exp("R5 level run", 8, 0);
    send_cmd(1);
    repeat (4) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();

    // R5 run-sync ignores an already active start
    quiet();
    start_evt = 1'b1;
    send_cmd(2);
    repeat (4) @(negedge clk);
    chk("R5 still waiting", int'(state), 10);
    push_exp("R5 sync run", 6, 0);
    start_evt = 1'b0;
    @(negedge clk);
    start_evt = 1'b1;
    repeat (3) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();

    // R6 saturation at limit 0 (threshold 16)
    quiet();
    sat_limit = 3'd0;
    push_exp("R6 sat limit0", 20, 1);
    send_cmd(2);
    start_evt = 1'b1;
    wait_done();
    chk("R6 sat flag", int'(sat), 1);
    send_cmd(3);
    chk("R7 clear done", int'(done), 0);
    chk("R7 clear sat", int'(sat), 0);
    chk("R7 clear result", int'(result), 2);

    // R6 saturation at limit 1 (threshold 32), then re-arm clears flags
    quiet();
    sat_limit = 3'd1;
    push_exp("R6 sat limit1", 36, 1);
    send_cmd(2);
    start_evt = 1'b1;
    wait_done();
    quiet();
    send_cmd(2);
    chk("R7 arm clears done", int'(done), 0);
    chk("R7 arm clears sat", int'(sat), 0);
    chk("R5 wait code", int'(state), 10);
    send_cmd(0);
    chk("R2 abort from wait", int'(state), 6);

    // R2 abort mid-count
    quiet();
    send_cmd(2);
    start_evt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 count code", int'(state), 15);
    send_cmd(0);
    chk("R2 abort state", int'(state), 6);
    chk("R2 abort no done", int'(done), 0);

    // R9 period measurement, start and stop on the same signal
    for (int n = 0; n < 3; n++) begin
      quiet();
      skip_en = 1'b1; skip_load = SKIP_W'(n);
      push_exp("R9 period", (n == 2) ? 24 : 12, 0);
      send_cmd(2);
      for (int k = 0; k < n + 3; k++) begin
        start_evt = 1'b1; stop_evt = 1'b1;
        repeat (3) @(negedge clk);
        start_evt = 1'b0; stop_evt = 1'b0;
        repeat (3) @(negedge clk);
      end
      chk("R9 period done", int'(done), 1);
    end

    // R9 pulse width: same signal, opposite polarities, skip 0
    quiet();
    skip_en = 1'b1; stop_pol = 1'b1;
    push_exp("R9 pulse width", 14, 0);
    send_cmd(2);
    start_evt = 1'b1; stop_evt = 1'b1;
    repeat (7) @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0;
    wait_done();

    // R8 third stop ends the measurement (skip 2)
    quiet();
    skip_en = 1'b1; skip_load = 8'd2;
    push_exp("R8 third stop", 24, 0);
    send_cmd(2);
    start_evt = 1'b1;
    repeat (4) @(negedge clk);
    stop_evt = 1'b1;
    for (int k = 0; k < 2; k++) begin
      repeat (2) @(negedge clk);
      stop_evt = 1'b0;
      repeat (2) @(negedge clk);
      stop_evt = 1'b1;
    end
    wait_done();

    // R10 live rewrite while nonzero
    quiet();
    skip_en = 1'b1; skip_load = 8'd6;
    push_exp("R10 rewrite", 18, 0);
    send_cmd(2);
    start_evt = 1'b1;
    @(negedge clk);
    chk("R8 load at start", int'(skip_live), 6);
    @(negedge clk);
    skip_wr = 1'b1; skip_wdata = 8'd1;
    @(negedge clk);
    skip_wr = 1'b0;
    chk("R10 rewrite taken", int'(skip_live), 1);
    repeat (2) @(negedge clk);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    repeat (3) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();

    // R10 write ignored when nothing left to skip
    quiet();
    skip_en = 1'b1; skip_load = 8'd0;
    push_exp("R10 ignored", 10, 0);
    send_cmd(2);
    start_evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    skip_wr = 1'b1; skip_wdata = 8'd5;
    @(negedge clk);
    skip_wr = 1'b0;
    chk("R10 write ignored", int'(skip_live), 0);
    repeat (2) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();

    // R11 skipping disabled at arm time
    quiet();
    skip_en = 1'b0; skip_load = 8'd3;
    push_exp("R11 no skip", 8, 0);
    send_cmd(2);
    start_evt = 1'b1;
    repeat (4) @(negedge clk);
    stop_evt = 1'b1;
    wait_done();
    chk("R11 live unchanged", int'(skip_live), 0);

    repeat (3) @(negedge clk);
    chk("R3 scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule